// File: doc/BRIEF.md
# Two-Level Weighted Bandwidth Arbiter

This block hands out the slots of one shared memory port to a set of requesters arranged in two levels. The upper level is a set of groups, each with its own reserved slot budget and a weight. The lower level is a set of classes inside each group, and each class also has a reserved slot budget and a weight. Each clock cycle is one slot. The block issues at most one grant per slot. Time is divided into accounting intervals of a fixed number of slots, and all budget use and sharing state starts fresh at each interval.

In every slot a requester that is still inside both its class reserve and its group reserve is served first, round-robin among such requesters. When no reserved request is pending, the spare slot is given away without leaving it idle. A group is picked in proportion to its weight among the groups that are contending. A class inside that group is then picked in proportion to its class weight. Proportions come from deficit credits, so no dividers are needed. A group with weight zero never takes part in spare sharing, so its reserve acts as a hard cap.

Configuration is a single write port with an operation code. A one-time limit operation sets a group's reserve and weight and also reports the reserve as the capability value. A class operation sets one class's reserve and weight. A registered status code reports the outcome of every write.

Top module: `qos_bw_arbiter`

## Requirements
- R1: After reset `gnt` is 0, `status` is 0 (idle) and `cap_rbwb` is 0, and all reserves and weights are 0, so no grant is issued until the block is configured.
- R2: `gnt` is one-hot or zero. Bit g*N_CLS+c stands for class c of group g. `gnt` is registered, so the request vector sampled at a clock edge gives its grant just after that edge. A slot with no eligible requester gives no grant.
- R3: A request is reserved-eligible while its class has used fewer slots than its class reserve and its group has used fewer slots than its group reserve in the current interval. Reserved-eligible requests always win over spare sharing and are served round-robin.
- R4: When a group's weight is 0, that group gets at most its reserve in slots per interval, even if slots are left idle.
- R5: Spare sharing is work-conserving. Any slot with no reserved-eligible request, but with a pending request from a class of nonzero weight in a group of nonzero weight, is granted.
- R6: Spare slots are split across contending groups in proportion to group weight. Group weights 2 and 1, with all four classes requesting over one 16-slot interval, give 11 and 5 slots.
- R7: Inside the chosen group, spare slots are split by class weight. Class weights 50 and 25 give 11 and 5 slots over a 16-slot interval.
- R8: Only groups with pending requests contend. A group that is the sole requester takes every spare slot.
- R9: An interval is SLOTS slots long. At each interval boundary, the used counters and sharing credits are cleared, so reserves refill.
- R10: Operation code 4 (group limit) writes the group's reserve and weight, copies the reserve to `cap_rbwb`, and sets `status` to 1 (ok). It ignores `cfg_cls`.
- R11: A second operation-code-4 write to the same group after reset sets `status` to 2 and leaves that group's reserve, its weight and `cap_rbwb` unchanged.
- R12: Operation code 1 writes the reserve and weight of class `cfg_cls` in group `cfg_grp` and sets `status` to 1. Any other code, or a group index out of range, sets `status` to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_GRP*N_CLS | Pending request per class, bit g*N_CLS+c |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Operation code: 1 class set, 4 group limit |
| cfg_grp | input | GIW | Target group index |
| cfg_cls | input | CIW | Target class index (class set only) |
| cfg_rbwb | input | CW | Reserved slots per interval |
| cfg_weight | input | WW | Sharing weight |
| gnt | output | N_GRP*N_CLS | One-hot grant for the slot just decided |
| status | output | 2 | 0 idle, 1 ok, 2 repeated limit, 3 bad operation |
| cap_rbwb | output | CW | Reserve taken by the last successful limit operation |

## Verification
The arbiter is driven with full 16-slot intervals of steady requests, each shaped to separate one policy from the others. Reserve-only groups with weight zero show the hard cap and round-robin within the reserve. A capped group requesting next to a spare-only group shows that reserved grants come first and that spare slots are not wasted. All classes requesting under unequal group weights, and then under unequal class weights, give exact 11/5 splits that a plain round-robin or a wrong level would miss. Back-to-back intervals, one with a sole requester, show reserve refill and that idle groups do not dilute the shares.

// File: rtl/bwa_pkg.sv
// Shared constants for the two-level bandwidth arbiter.
// Assumes a 3-bit operation code and a 2-bit status code.
package bwa_pkg;
    localparam logic [2:0] OP_CLS_SET   = 3'd1;
    localparam logic [2:0] OP_GRP_LIMIT = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OK     = 2'd1,
        ST_REPEAT = 2'd2,
        ST_BADOP  = 2'd3
    } status_e;
endpackage

// File: rtl/bwa_cfg.sv
// Configuration registers: group reserve/weight (one-time limit operation),
// class reserve/weight, capability value and status code.
// Assumes at most one write per cycle; writes take effect at the next edge.
module bwa_cfg
    import bwa_pkg::*;
#(
    parameter int N_GRP = 2,
    parameter int N_CLS = 2,
    parameter int CW    = 5,
    parameter int WW    = 8,
    localparam int NR   = N_GRP * N_CLS,
    localparam int GIW  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int CIW  = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [2:0]                  cfg_op,
    input  logic [GIW-1:0]              cfg_grp,
    input  logic [CIW-1:0]              cfg_cls,
    input  logic [CW-1:0]               cfg_rbwb,
    input  logic [WW-1:0]               cfg_weight,
    output logic [N_GRP-1:0][CW-1:0]    g_rbwb,
    output logic [N_GRP-1:0][WW-1:0]    g_wt,
    output logic [NR-1:0][CW-1:0]       c_rbwb,
    output logic [NR-1:0][WW-1:0]       c_wt,
    output logic [1:0]                  status,
    output logic [CW-1:0]               cap_rbwb
);
    logic [N_GRP-1:0] limit_done;
    logic             grp_ok;
    logic             cls_ok;
    int               cls_idx;

    // Decode whether the addressed group and class exist.
    always_comb begin
        grp_ok  = int'(cfg_grp) < N_GRP;
        cls_ok  = int'(cfg_cls) < N_CLS;
        cls_idx = int'(cfg_grp) * N_CLS + int'(cfg_cls);
    end

    // Apply configuration writes and record the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_rbwb     <= '0;
            g_wt       <= '0;
            c_rbwb     <= '0;
            c_wt       <= '0;
            limit_done <= '0;
            cap_rbwb   <= '0;
            status     <= ST_IDLE;
        end else if (cfg_we) begin
            if (cfg_op == OP_GRP_LIMIT && grp_ok) begin
                if (limit_done[cfg_grp]) begin
                    status <= ST_REPEAT;
                end else begin
                    g_rbwb[cfg_grp]     <= cfg_rbwb;
                    g_wt[cfg_grp]       <= cfg_weight;
                    limit_done[cfg_grp] <= 1'b1;
                    cap_rbwb            <= cfg_rbwb;
                    status              <= ST_OK;
                end
            end else if (cfg_op == OP_CLS_SET && grp_ok && cls_ok) begin
                c_rbwb[cls_idx] <= cfg_rbwb;
                c_wt[cls_idx]   <= cfg_weight;
                status          <= ST_OK;
            end else begin
                status <= ST_BADOP;
            end
        end
    end

    AST_REPEAT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_op == OP_GRP_LIMIT && grp_ok && limit_done[cfg_grp]) |=> (status == ST_REPEAT)); // R11
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) |=> $stable(cap_rbwb)); // R10
    AST_BADOP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_op != OP_GRP_LIMIT && cfg_op != OP_CLS_SET) |=> (status == ST_BADOP)); // R12
endmodule

// File: rtl/bwa_pick.sv
// Picks the valid entry with the largest signed value. Ties are broken
// round-robin from a rotating pointer that moves past the winner on adv.
// Assumes adv is only raised when found is high.
module bwa_pick #(
    parameter int N  = 4,
    parameter int VW = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][VW-1:0] val,
    input  logic                 adv,
    output logic                 found,
    output logic [IW-1:0]        idx
);
    logic [IW-1:0] ptr;
    logic [VW-1:0] best;

    // Scan in rotated order; a strict compare keeps the earliest tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (valid[j] && (!found || $signed(val[j]) > $signed(best))) begin
                found = 1'b1;
                idx   = IW'(j);
                best  = val[j];
            end
        end
    end

    // Move the tie-break pointer past the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
        end
    end

    AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> valid[idx]); // R2
endmodule

// File: rtl/qos_bw_arbiter.sv
// Two-level weighted slot arbiter. Each cycle is a slot: reserved requests
// are served first, then spare slots go to a group by weight and to a class
// of that group by weight, using deficit credits. Counters and credits clear
// every SLOTS slots. Assumes SLOTS >= 2 and reserves that fit in CW bits.
module qos_bw_arbiter
    import bwa_pkg::*;
#(
    parameter int N_GRP = 2,
    parameter int N_CLS = 2,
    parameter int SLOTS = 16,
    parameter int CW    = 5,
    parameter int WW    = 8,
    localparam int NR   = N_GRP * N_CLS,
    localparam int GIW  = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int CIW  = (N_CLS > 1) ? $clog2(N_CLS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NR-1:0]   req,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_op,
    input  logic [GIW-1:0]  cfg_grp,
    input  logic [CIW-1:0]  cfg_cls,
    input  logic [CW-1:0]   cfg_rbwb,
    input  logic [WW-1:0]   cfg_weight,
    output logic [NR-1:0]   gnt,
    output logic [1:0]      status,
    output logic [CW-1:0]   cap_rbwb
);
    localparam int SW  = $clog2(SLOTS);
    localparam int CRW = WW + $clog2(SLOTS) + $clog2(NR + 1) + 3;
    localparam int RIW = (NR > 1) ? $clog2(NR) : 1;

    logic [N_GRP-1:0][CW-1:0]  g_rbwb;
    logic [N_GRP-1:0][WW-1:0]  g_wt;
    logic [NR-1:0][CW-1:0]     c_rbwb;
    logic [NR-1:0][WW-1:0]     c_wt;

    logic [SW-1:0]             slot_cnt;
    logic                      last_slot;
    logic [N_GRP-1:0][CW-1:0]  g_used;
    logic [NR-1:0][CW-1:0]     c_used;
    logic [N_GRP-1:0][CRW-1:0] g_cred;
    logic [NR-1:0][CRW-1:0]    c_cred;

    logic [NR-1:0]             res_ok;
    logic [NR-1:0]             c_cont;
    logic [N_GRP-1:0]          g_cont;
    logic [N_GRP-1:0][CRW-1:0] g_val;
    logic [NR-1:0][CRW-1:0]    c_val;
    logic                      res_found;
    logic [RIW-1:0]            res_idx;
    logic                      g_found;
    logic [GIW-1:0]            g_idx;
    logic [N_GRP-1:0]          c_found;
    logic [N_GRP-1:0][CIW-1:0] c_idx;
    logic                      spare_go;
    logic [NR-1:0]             gnt_nxt;
    int                        win;
    int                        win_g;
    logic [CRW-1:0]            g_sum;
    logic [CRW-1:0]            c_sum;

    bwa_cfg #(.N_GRP(N_GRP), .N_CLS(N_CLS), .CW(CW), .WW(WW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_grp(cfg_grp), .cfg_cls(cfg_cls), .cfg_rbwb(cfg_rbwb),
        .cfg_weight(cfg_weight), .g_rbwb(g_rbwb), .g_wt(g_wt),
        .c_rbwb(c_rbwb), .c_wt(c_wt), .status(status), .cap_rbwb(cap_rbwb)
    );

    // Eligibility per class for the reserved and spare phases.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            res_ok[i] = req[i] && (c_used[i] < c_rbwb[i]) && (g_used[i / N_CLS] < g_rbwb[i / N_CLS]);
            c_cont[i] = req[i] && (c_wt[i] != '0);
            c_val[i]  = c_cred[i] + {{(CRW-WW){1'b0}}, c_wt[i]};
        end
        for (int g = 0; g < N_GRP; g++) begin
            g_cont[g] = (g_wt[g] != '0) && (c_cont[g*N_CLS +: N_CLS] != '0);
            g_val[g]  = g_cred[g] + {{(CRW-WW){1'b0}}, g_wt[g]};
        end
    end

    bwa_pick #(.N(NR), .VW(1)) u_res_pick (
        .clk(clk), .rst_n(rst_n), .valid(res_ok), .val('0),
        .adv(res_found), .found(res_found), .idx(res_idx)
    );

    bwa_pick #(.N(N_GRP), .VW(CRW)) u_grp_pick (
        .clk(clk), .rst_n(rst_n), .valid(g_cont), .val(g_val),
        .adv(spare_go), .found(g_found), .idx(g_idx)
    );

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_cls_pick
            bwa_pick #(.N(N_CLS), .VW(CRW)) u_cls_pick (
                .clk(clk), .rst_n(rst_n), .valid(c_cont[g*N_CLS +: N_CLS]),
                .val(c_val[g*N_CLS +: N_CLS]),
                .adv(spare_go && (int'(g_idx) == g)),
                .found(c_found[g]), .idx(c_idx[g])
            );
        end
    endgenerate

    // Choose the slot winner: reserved first, otherwise the spare pick.
    always_comb begin
        spare_go = !res_found && g_found && c_found[g_idx];
        gnt_nxt  = '0;
        win      = 0;
        if (res_found) begin
            win = int'(res_idx);
            gnt_nxt[res_idx] = 1'b1;
        end else if (spare_go) begin
            win = int'(g_idx) * N_CLS + int'(c_idx[g_idx]);
            gnt_nxt[win] = 1'b1;
        end
        win_g = win / N_CLS;
    end

    // Total weight of the contenders at each sharing level.
    always_comb begin
        g_sum = '0;
        c_sum = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (g_cont[g]) g_sum = g_sum + {{(CRW-WW){1'b0}}, g_wt[g]};
        end
        for (int c = 0; c < N_CLS; c++) begin
            if (c_cont[int'(g_idx)*N_CLS + c])
                c_sum = c_sum + {{(CRW-WW){1'b0}}, c_wt[int'(g_idx)*N_CLS + c]};
        end
        last_slot = (slot_cnt == SW'(SLOTS - 1));
    end

    // Slot counter, usage counters, deficit credits and grant register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            g_used   <= '0;
            c_used   <= '0;
            g_cred   <= '0;
            c_cred   <= '0;
            gnt      <= '0;
        end else begin
            gnt      <= gnt_nxt;
            slot_cnt <= last_slot ? '0 : slot_cnt + 1'b1;
            if (last_slot) begin
                g_used <= '0;
                c_used <= '0;
                g_cred <= '0;
                c_cred <= '0;
            end else begin
                if (gnt_nxt != '0) begin
                    if (g_used[win_g] != '1) g_used[win_g] <= g_used[win_g] + 1'b1;
                    if (c_used[win] != '1)   c_used[win]   <= c_used[win] + 1'b1;
                end
                if (spare_go) begin
                    for (int g = 0; g < N_GRP; g++) begin
                        g_cred[g] <= g_cred[g]
                            + (g_cont[g] ? {{(CRW-WW){1'b0}}, g_wt[g]} : '0)
                            - ((g == int'(g_idx)) ? g_sum : '0);
                    end
                    for (int c = 0; c < N_CLS; c++) begin
                        c_cred[int'(g_idx)*N_CLS + c] <= c_cred[int'(g_idx)*N_CLS + c]
                            + (c_cont[int'(g_idx)*N_CLS + c] ? {{(CRW-WW){1'b0}}, c_wt[int'(g_idx)*N_CLS + c]} : '0)
                            - ((c == int'(c_idx[g_idx])) ? c_sum : '0);
                    end
                end
            end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> (gnt == '0)); // R2
    AST_SPARE_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_ok == '0) && (g_cont != '0)) |=> (gnt != '0)); // R5

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_cap_chk
            AST_HARD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                ((gnt_nxt[g*N_CLS +: N_CLS] != '0) && (g_wt[g] == '0)) |-> (g_used[g] < g_rbwb[g])); // R4
        end
    endgenerate
endmodule

// File: tb/qos_bw_arbiter_bench.sv
module qos_bw_arbiter_bench;
    localparam int NG = 2;
    localparam int NC = 2;
    localparam int NR = NG * NC;
    localparam int SL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_op = '0;
    logic [0:0] cfg_grp = '0;
    logic [0:0] cfg_cls = '0;
    logic [4:0] cfg_rbwb = '0;
    logic [7:0] cfg_weight = '0;
    logic [3:0] gnt;
    logic [1:0] status;
    logic [4:0] cap_rbwb;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cnt [NR];
    logic [3:0] gnt_log [SL];

    qos_bw_arbiter #(.N_GRP(NG), .N_CLS(NC), .SLOTS(SL), .CW(5), .WW(8)) u_qos_bw_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .cfg_op(cfg_op),
        .cfg_grp(cfg_grp), .cfg_cls(cfg_cls), .cfg_rbwb(cfg_rbwb),
        .cfg_weight(cfg_weight), .gnt(gnt), .status(status), .cap_rbwb(cap_rbwb)
    );

    always #10 clk = ~clk;

    // Mirror of the slot phase, counted from reset release.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cfg(input logic [2:0] op, input int g, input int c, input int rb, input int w);
        cfg_op = op; cfg_grp = 1'(g); cfg_cls = 1'(c);
        cfg_rbwb = 5'(rb); cfg_weight = 8'(w); cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one full interval with a steady request vector and count grants.
    task automatic run_interval(input logic [3:0] r);
        while (cyc % SL != 0) @(negedge clk);
        for (int i = 0; i < NR; i++) cnt[i] = 0;
        req = r;
        for (int s = 0; s < SL; s++) begin
            @(negedge clk);
            gnt_log[s] = gnt;
            for (int i = 0; i < NR; i++) if (gnt[i]) cnt[i]++;
        end
        req = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(gnt == '0, "R1 gnt after reset", int'(gnt), 0);
        chk(status == 2'd0, "R1 status after reset", int'(status), 0);
        chk(cap_rbwb == '0, "R1 cap after reset", int'(cap_rbwb), 0);
        run_interval(4'b1111);
        chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] == 0, "R1 R2 no grant unconfigured",
            cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
    endtask

    task automatic t_hard_cap();
        do_reset();
        cfg(3'd4, 0, 1, 6, 0);
        chk(status == 2'd1, "R10 limit status", int'(status), 1);
        chk(cap_rbwb == 5'd6, "R10 cap value", int'(cap_rbwb), 6);
        cfg(3'd4, 0, 0, 10, 3);
        chk(status == 2'd2, "R11 repeat status", int'(status), 2);
        chk(cap_rbwb == 5'd6, "R11 cap unchanged", int'(cap_rbwb), 6);
        cfg(3'd1, 0, 0, 4, 1);
        chk(status == 2'd1, "R12 class set status", int'(status), 1);
        cfg(3'd1, 0, 1, 4, 1);
        for (int k = 0; k < 2; k++) begin
            run_interval(4'b0011);
            chk(cnt[0] + cnt[1] == 6, "R4 R11 R9 capped total", cnt[0] + cnt[1], 6);
            chk(cnt[0] == 3, "R3 round-robin in reserve", cnt[0], 3);
        end
    endtask

    task automatic t_reserve_then_spare();
        do_reset();
        cfg(3'd4, 0, 0, 8, 0);
        cfg(3'd4, 1, 0, 0, 1);
        cfg(3'd1, 0, 0, 8, 1);
        cfg(3'd1, 1, 0, 0, 1);
        run_interval(4'b0101);
        chk(gnt_log[0] == 4'b0001, "R3 reserved wins first slot", int'(gnt_log[0]), 1);
        chk(gnt_log[8] == 4'b0100, "R3 spare after reserve used", int'(gnt_log[8]), 4);
        chk(cnt[0] == 8, "R4 capped group", cnt[0], 8);
        chk(cnt[2] == 8, "R5 spare not idle", cnt[2], 8);
    endtask

    task automatic t_group_share();
        do_reset();
        cfg(3'd4, 0, 0, 0, 2);
        cfg(3'd4, 1, 0, 0, 1);
        for (int i = 0; i < NR; i++) cfg(3'd1, i / NC, i % NC, 0, 1);
        run_interval(4'b1111);
        chk(cnt[0] + cnt[1] == 11, "R6 heavy group share", cnt[0] + cnt[1], 11);
        chk(cnt[2] + cnt[3] == 5, "R6 light group share", cnt[2] + cnt[3], 5);
        run_interval(4'b0011);
        chk(cnt[0] + cnt[1] == 16, "R8 R9 sole requester", cnt[0] + cnt[1], 16);
    endtask

    task automatic t_class_share();
        do_reset();
        cfg(3'd4, 0, 0, 0, 5);
        cfg(3'd1, 0, 0, 0, 50);
        cfg(3'd1, 0, 1, 0, 25);
        run_interval(4'b0011);
        chk(cnt[0] == 11, "R7 weight 50 class", cnt[0], 11);
        chk(cnt[1] == 5, "R7 weight 25 class", cnt[1], 5);
    endtask

    task automatic t_bad_op();
        do_reset();
        cfg(3'd2, 0, 0, 1, 1);
        chk(status == 2'd3, "R12 unknown op", int'(status), 3);
        chk(cap_rbwb == '0, "R12 cap untouched", int'(cap_rbwb), 0);
    endtask

    initial begin
        t_reset();
        t_hard_cap();
        t_reserve_then_spare();
        t_group_share();
        t_class_share();
        t_bad_op();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule